// File: doc/BRIEF.md
# SMI Feature Negotiation and Dispatch

This block agrees on a 64-bit set of system-management-interrupt features between what the host offers and what the guest firmware asks for. Firmware writes the features it wants into a request register, then pulses a confirm strobe. The block checks the request against the host's offer and against dependency rules between three feature bits. If the request passes, the block copies it into a negotiated register and raises an agreed flag. From then on the result is locked until the next reset. A request that fails can be corrected and confirmed again.

The negotiated broadcast bit controls how a write to the power-management command port raises SMI. Two command codes only switch the ACPI enable state. Any other code raises SMI when the command-port SMI enable input is set. The SMI goes to every processor when broadcast was agreed, and otherwise only to the processor that issued the write. Each SMI request is a one-cycle pulse on a per-processor vector.

Top module: `smi_feat_dispatch_top`

## Requirements
- R1: After a synchronous reset, the request register, the agreed flag, the negotiated register, the ACPI enable state and the SMI vector are all zero.
- R2: A confirm strobe while the agreed flag is 0 validates the request register as it held before that clock edge. If the request is valid, the request is copied to the negotiated output and the agreed flag reads 1 one cycle after the strobe.
- R3: A request that sets any bit the host feature input does not offer is rejected: the agreed flag stays 0 and the negotiated output stays zero.
- R4: Bit 0 is broadcast, bit 1 is hotplug and bit 2 is hot-unplug. A request with bit 1 or bit 2 set and bit 0 clear is rejected.
- R5: A request with bit 2 set and bit 1 clear is rejected.
- R6: Once the agreed flag is 1, further confirm strobes do nothing and the negotiated output holds its value. The request register stays writable and reads back its new value.
- R7: A rejected request can be replaced and confirmed again. A later valid request then succeeds.
- R8: A command write of code 0xF0 sets the ACPI enable state and code 0xF1 clears it. Neither code ever raises SMI.
- R9: A command write of any other code raises no SMI while the SMI enable input is 0.
- R10: With the SMI enable input at 1 and broadcast negotiated, any other code sets every bit of the SMI vector for exactly one cycle, one cycle after the write.
- R11: With the SMI enable input at 1 and broadcast not negotiated, any other code sets only the SMI vector bit selected by the issuing-processor index, for exactly one cycle, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_feat_i | input | FEAT_W | Features the host offers |
| req_wr_i | input | 1 | Write strobe for the request register |
| req_data_i | input | FEAT_W | Requested feature set |
| confirm_i | input | 1 | Confirm strobe that triggers validation |
| req_feat_o | output | FEAT_W | Readback of the request register |
| agreed_o | output | 1 | Negotiation succeeded and is locked |
| nego_feat_o | output | FEAT_W | Negotiated feature set |
| cmd_wr_i | input | 1 | Command-port write strobe |
| cmd_code_i | input | 8 | Command-port write value |
| cmd_cpu_i | input | IDX_W | Index of the processor issuing the write |
| apmc_smi_en_i | input | 1 | SMI enable for command-port writes |
| acpi_en_o | output | 1 | ACPI enable state |
| smi_req_o | output | N_CPU | Per-processor SMI request pulses |

## Verification
The hardest situation to reach is the locked state meeting a new request that would also pass validation. The only way to show that the lock holds is to offer a second request that would succeed if the lock were missing. The bench negotiates one set, writes a different valid set, confirms again, and checks that the negotiated output keeps the first set while the readback shows the second. Dispatch is then swept over every processor index, several command codes and both enable levels. This is done once under each broadcast outcome, and each broadcast outcome is reached by a fresh reset and negotiation.

// File: rtl/smi_feat_pkg.sv
package smi_feat_pkg;
  // feature bit positions, decoded by the dispatcher and firmware
  localparam int unsigned BIT_BCAST   = 0;
  localparam int unsigned BIT_HOTPLUG = 1;
  localparam int unsigned BIT_UNPLUG  = 2;
  // command-port codes that only touch the ACPI enable state
  localparam logic [7:0] CODE_ACPI_ON  = 8'hF0;
  localparam logic [7:0] CODE_ACPI_OFF = 8'hF1;
endpackage

// File: rtl/smi_feat_negotiate.sv
module smi_feat_negotiate
  import smi_feat_pkg::*;
#(
  parameter int unsigned FEAT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FEAT_W-1:0] host_i,
  input  logic              req_wr_i,
  input  logic [FEAT_W-1:0] req_data_i,
  input  logic              confirm_i,
  output logic [FEAT_W-1:0] req_o,
  output logic              agreed_o,
  output logic [FEAT_W-1:0] nego_o
);
  logic [FEAT_W-1:0] req_q, nego_q;
  logic              agreed_q;
  logic              extra_bits, hp_no_bc, unplug_no_hp, accept;

  always_comb begin
    extra_bits   = |(req_q & ~host_i);
    hp_no_bc     = (req_q[BIT_HOTPLUG] | req_q[BIT_UNPLUG]) & ~req_q[BIT_BCAST];
    unplug_no_hp = req_q[BIT_UNPLUG] & ~req_q[BIT_HOTPLUG];
    accept       = confirm_i & ~agreed_q & ~extra_bits & ~hp_no_bc & ~unplug_no_hp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      nego_q   <= '0;
      agreed_q <= 1'b0;
    end else begin
      if (req_wr_i) req_q <= req_data_i;
      if (accept) begin
        nego_q   <= req_q;
        agreed_q <= 1'b1;
      end
    end
  end

  assign req_o    = req_q;
  assign agreed_o = agreed_q;
  assign nego_o   = nego_q;

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    agreed_q |=> (agreed_q && $stable(nego_q)));
  // R3
  nego_subset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(agreed_q) |-> ((nego_q & ~$past(host_i)) == '0));
  // R5
  unplug_dep_chk: assert property (@(posedge clk) disable iff (rst)
    agreed_q |-> !(nego_q[BIT_UNPLUG] && !nego_q[BIT_HOTPLUG]));
  // R4
  bcast_dep_chk: assert property (@(posedge clk) disable iff (rst)
    agreed_q |-> !((nego_q[BIT_HOTPLUG] || nego_q[BIT_UNPLUG]) && !nego_q[BIT_BCAST]));
  // R2
  empty_until_agreed_chk: assert property (@(posedge clk) disable iff (rst)
    !agreed_q |-> (nego_q == '0));
endmodule

// File: rtl/smi_cmd_dispatch.sv
module smi_cmd_dispatch
  import smi_feat_pkg::*;
#(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr_i,
  input  logic [7:0]       cmd_code_i,
  input  logic [IDX_W-1:0] cmd_cpu_i,
  input  logic             smi_en_i,
  input  logic             bcast_i,
  output logic             acpi_en_o,
  output logic [N_CPU-1:0] smi_o
);
  logic             is_on, is_off, fire, acpi_q;
  logic [N_CPU-1:0] smi_d, smi_q;

  always_comb begin
    is_on  = (cmd_code_i == CODE_ACPI_ON);
    is_off = (cmd_code_i == CODE_ACPI_OFF);
    fire   = cmd_wr_i & smi_en_i & ~is_on & ~is_off;
  end

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    assign smi_d[g] = fire & (bcast_i | (cmd_cpu_i == IDX_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acpi_q <= 1'b0;
      smi_q  <= '0;
    end else begin
      smi_q <= smi_d;
      if (cmd_wr_i && is_on)  acpi_q <= 1'b1;
      if (cmd_wr_i && is_off) acpi_q <= 1'b0;
    end
  end

  assign acpi_en_o = acpi_q;
  assign smi_o     = smi_q;

  // R8
  acpi_no_smi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_i && (cmd_code_i == CODE_ACPI_ON || cmd_code_i == CODE_ACPI_OFF)) |=> (smi_q == '0));
  // R9
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    !smi_en_i |=> (smi_q == '0));
  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    !bcast_i |=> $onehot0(smi_q));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr_i |=> (smi_q == '0));
endmodule

// File: rtl/smi_feat_dispatch_top.sv
module smi_feat_dispatch_top
  import smi_feat_pkg::*;
#(
  parameter int unsigned FEAT_W = 64,
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned IDX_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FEAT_W-1:0] host_feat_i,
  input  logic              req_wr_i,
  input  logic [FEAT_W-1:0] req_data_i,
  input  logic              confirm_i,
  output logic [FEAT_W-1:0] req_feat_o,
  output logic              agreed_o,
  output logic [FEAT_W-1:0] nego_feat_o,
  input  logic              cmd_wr_i,
  input  logic [7:0]        cmd_code_i,
  input  logic [IDX_W-1:0]  cmd_cpu_i,
  input  logic              apmc_smi_en_i,
  output logic              acpi_en_o,
  output logic [N_CPU-1:0]  smi_req_o
);
  logic [FEAT_W-1:0] nego_w;

  smi_feat_negotiate #(.FEAT_W(FEAT_W)) u_neg (
    .clk(clk), .rst(rst), .host_i(host_feat_i),
    .req_wr_i(req_wr_i), .req_data_i(req_data_i), .confirm_i(confirm_i),
    .req_o(req_feat_o), .agreed_o(agreed_o), .nego_o(nego_w)
  );

  smi_cmd_dispatch #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_disp (
    .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr_i), .cmd_code_i(cmd_code_i),
    .cmd_cpu_i(cmd_cpu_i), .smi_en_i(apmc_smi_en_i), .bcast_i(nego_w[BIT_BCAST]),
    .acpi_en_o(acpi_en_o), .smi_o(smi_req_o)
  );

  assign nego_feat_o = nego_w;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (req_feat_o == '0 && !agreed_o && nego_feat_o == '0 && smi_req_o == '0 && !acpi_en_o));
endmodule

// File: tb/smi_feat_dispatch_top_tb.sv
module smi_feat_dispatch_top_tb;
  localparam int FW = 64;
  localparam int NC = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic [FW-1:0] host, req_data, req_feat, nego;
  logic req_wr, confirm, agreed, cmd_wr, smi_en, acpi_en;
  logic [7:0] code;
  logic [IW-1:0] cpu;
  logic [NC-1:0] smi;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smi_feat_dispatch_top #(.FEAT_W(FW), .N_CPU(NC), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .host_feat_i(host), .req_wr_i(req_wr), .req_data_i(req_data),
    .confirm_i(confirm), .req_feat_o(req_feat), .agreed_o(agreed), .nego_feat_o(nego),
    .cmd_wr_i(cmd_wr), .cmd_code_i(code), .cmd_cpu_i(cpu), .apmc_smi_en_i(smi_en),
    .acpi_en_o(acpi_en), .smi_req_o(smi)
  );

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_wr = 0; confirm = 0; cmd_wr = 0; smi_en = 0;
    req_data = '0; code = '0; cpu = '0;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic write_req(logic [FW-1:0] v);
    @(negedge clk); req_wr = 1; req_data = v;
    @(negedge clk); req_wr = 0;
  endtask

  task automatic do_confirm();
    @(negedge clk); confirm = 1;
    @(negedge clk); confirm = 0;
  endtask

  function automatic bit valid_req(logic [FW-1:0] r, logic [FW-1:0] h);
    return ((r & ~h) == '0) && !((r[1] || r[2]) && !r[0]) && !(r[2] && !r[1]);
  endfunction

  task automatic send_cmd(logic [7:0] c, int p, bit en);
    @(negedge clk); cmd_wr = 1; code = c; cpu = IW'(p); smi_en = en;
    @(negedge clk); cmd_wr = 0;
  endtask

  initial begin
    logic [FW-1:0] hosts [6];
    logic [7:0] codes [5];
    hosts[0] = 64'h7; hosts[1] = 64'h5; hosts[2] = 64'h3;
    hosts[3] = 64'h1; hosts[4] = 64'h0; hosts[5] = 64'h7 | (64'h1 << 40);
    codes[0] = 8'hF0; codes[1] = 8'h00; codes[2] = 8'hF1; codes[3] = 8'hB2; codes[4] = 8'hFF;
    host = 64'h7;
    do_reset();
    chk("R1 req", req_feat, '0);
    chk("R1 agreed", {63'b0, agreed}, '0);
    chk("R1 nego", nego, '0);
    chk("R1 acpi", {63'b0, acpi_en}, '0);
    chk("R1 smi", {60'b0, smi}, '0);

    // sweep of request patterns against several host offers (R2 R3 R4 R5)
    for (int h = 0; h < 6; h++) begin
      for (int r = 0; r < 16; r++) begin
        logic [FW-1:0] rv;
        bit ok;
        rv = FW'(r & 7) | ((r >= 8) ? (64'h1 << 40) : '0);
        host = hosts[h];
        do_reset();
        write_req(rv);
        do_confirm();
        ok = valid_req(rv, hosts[h]);
        if (rv[2] && !rv[1]) chk("R5 agreed", {63'b0, agreed}, {63'b0, ok});
        else if ((rv[1] || rv[2]) && !rv[0]) chk("R4 agreed", {63'b0, agreed}, {63'b0, ok});
        else if ((rv & ~hosts[h]) != '0) chk("R3 agreed", {63'b0, agreed}, {63'b0, ok});
        else chk("R2 agreed", {63'b0, agreed}, {63'b0, ok});
        chk("R2 nego", nego, ok ? rv : '0);
      end
    end

    // R7 retry after rejection, then R6 lock
    host = 64'h7;
    do_reset();
    write_req(64'h4);
    do_confirm();
    chk("R7 rejected", {63'b0, agreed}, '0);
    write_req(64'h1);
    do_confirm();
    chk("R7 agreed", {63'b0, agreed}, 64'h1);
    chk("R7 nego", nego, 64'h1);
    write_req(64'h7);
    do_confirm();
    chk("R6 nego held", nego, 64'h1);
    chk("R6 agreed held", {63'b0, agreed}, 64'h1);
    chk("R6 req readback", req_feat, 64'h7);
    // R1 reset clears a locked state
    do_reset();
    chk("R1 relock nego", nego, '0);
    chk("R1 relock req", req_feat, '0);

    // dispatch sweep under both broadcast outcomes
    for (int b = 0; b < 2; b++) begin
      host = 64'h7;
      do_reset();
      write_req(b ? 64'h1 : 64'h0);
      do_confirm();
      for (int en = 0; en < 2; en++) begin
        for (int ci = 0; ci < 5; ci++) begin
          for (int p = 0; p < NC; p++) begin
            logic [NC-1:0] exp;
            bit acpi_code;
            acpi_code = (codes[ci] == 8'hF0) || (codes[ci] == 8'hF1);
            if (acpi_code || en == 0) exp = '0;
            else if (b) exp = '1;
            else exp = NC'(1) << p;
            send_cmd(codes[ci], p, bit'(en));
            if (acpi_code) begin
              chk("R8 smi", {60'b0, smi}, '0);
              chk("R8 acpi", {63'b0, acpi_en}, (codes[ci] == 8'hF0) ? 64'h1 : 64'h0);
            end else if (en == 0) chk("R9 smi", {60'b0, smi}, '0);
            else if (b) chk("R10 smi", {60'b0, smi}, {60'b0, exp});
            else chk("R11 smi", {60'b0, smi}, {60'b0, exp});
            @(negedge clk);
            chk(b ? "R10 pulse end" : "R11 pulse end", {60'b0, smi}, '0);
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule